// File: doc/BRIEF.md
# Per-Class Read Bandwidth Limiter

This block sits in the path of cacheable external read requests and keeps each class of service below an absolute read-rate ceiling. Each request carries a class tag and crosses a valid/ready handshake. For every class the block holds a limit register and a credit counter. Each accepted request spends one credit. Every refill interval of `CYC_PER_INT` clock cycles, the class's limit value is added back as credits. A request whose class has no credits left is held off until the next refill.

A limit value counts fixed-size lines per refill interval. The designer picks `CYC_PER_INT` so that one unit stands for 1/8 GB/s at the target clock and line size. One bit sits directly above the limit field and marks the class as unlimited. When that bit is set, the class is never throttled and spends no credits. At reset every class is unlimited. Every requester that carries a given class draws on the same counter. Bandwidth is never rebalanced between classes. The stream is served in order, so a stalled request at the head holds back whatever follows it.

Top module: `rd_bw_limiter`

## Requirements
- R1: After reset every limit register reads back as only the unlimited bit set (value `1 << BW_LEN`), and a request of any class is passed with `req_ready_o` equal to `out_ready_i`.
- R2: A limit register keeps the limit value in bits `[BW_LEN-1:0]` and the unlimited flag in bit `BW_LEN`. `reg_rdata_o` always shows, zero-extended, the register selected by `reg_addr_i`. An accepted write is visible there from the next cycle on.
- R3: A write that has any bit above `BW_LEN` set drives `reg_err_o` high in the same cycle. Such a write is dropped: the register and that class's credits are unchanged.
- R4: While a class has its unlimited bit set, its limit field has no effect. Its requests are never stalled, and accepting them leaves its credits unchanged.
- R5: For a limited class, each handshake (`out_valid_o && out_ready_i`) spends one credit. While its credits are zero, `out_valid_o` and `req_ready_o` stay low for its requests.
- R6: A refill happens on the clock edge that ends every `CYC_PER_INT`-th cycle counted from reset release. At each refill every class gains its limit value in credits, and the result saturates at `BURST_MAX`. A refill and a spend in the same cycle both take effect.
- R7: Reset, and every accepted write to a class's limit register, set that class's credits to `BURST_MAX`. If a write and a spend hit the same class in the same cycle, the write wins.
- R8: Credits belong to a class, not to a requester. A stall, spend or write of one class leaves the credits of every other class unchanged.
- R9: `out_cls_o` equals `req_cls_i`. `out_valid_o` is `req_valid_i` and `req_ready_o` is `out_ready_i`, both gated by whether the request's class may pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Limit register write strobe |
| reg_addr_i | input | CLS_W | Class index for register write and readback |
| reg_wdata_i | input | DATA_W | Write data: limit field, unlimited bit, reserved bits above |
| reg_rdata_o | output | DATA_W | Readback of the selected limit register |
| reg_err_o | output | 1 | Write touched reserved bits and was dropped |
| req_valid_i | input | 1 | Upstream read request valid |
| req_cls_i | input | CLS_W | Class of the upstream request |
| req_ready_o | output | 1 | Upstream ready |
| out_valid_o | output | 1 | Downstream request valid |
| out_cls_o | output | CLS_W | Class of the downstream request |
| out_ready_i | input | 1 | Downstream ready |

## Verification
A credit counter that drifts shows up at the ports as a wrong `req_ready_o`: a stall that comes too early or too late, within at most one burst and one refill interval. The bench models credits per class and compares the ready and valid outputs in every cycle, so a wrong count is caught on the first cycle it changes a decision. A stored limit that is corrupted shows at once on `reg_rdata_o`. A refill that comes at the wrong phase shows on the first stalled cycle after the refill was due.

// File: rtl/bwl_pkg.sv
package bwl_pkg;
  localparam int unsigned BWL_DEF_CLS   = 4;
  localparam int unsigned BWL_DEF_BWLEN = 11;
  localparam int unsigned BWL_DEF_DATAW = 16;
  localparam int unsigned BWL_DEF_CYC   = 16;
  localparam int unsigned BWL_DEF_BURST = 8;

  function automatic int unsigned bwl_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/bwl_tick_gen.sv
module bwl_tick_gen #(
  parameter int unsigned CYC_PER_INT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (CYC_PER_INT < 2) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_cnt
      localparam int unsigned TC_W = $clog2(CYC_PER_INT);
      localparam logic [TC_W-1:0] TC_LAST = TC_W'(CYC_PER_INT - 1);
      logic [TC_W-1:0] cnt_q;

      assign tick_o = (cnt_q == TC_LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
      end

      p_tick_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/bwl_limit_bank.sv
module bwl_limit_bank #(
  parameter int unsigned NUM_CLS = 4,
  parameter int unsigned BW_LEN  = 11,
  parameter int unsigned DATA_W  = 16,
  localparam int unsigned CLS_W  = (NUM_CLS > 1) ? $clog2(NUM_CLS) : 1,
  localparam int unsigned LIM_W  = BW_LEN + 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [CLS_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rdata_o,
  output logic                            err_o,
  output logic [NUM_CLS-1:0][LIM_W-1:0]   lim_o,
  output logic [NUM_CLS-1:0]              load_o
);
  localparam logic [LIM_W-1:0] LIM_RST = LIM_W'(1) << BW_LEN;

  logic [NUM_CLS-1:0][LIM_W-1:0] lim_q;
  logic                          wr_ok;

  assign err_o   = we_i && (|wdata_i[DATA_W-1:LIM_W]);
  assign wr_ok   = we_i && !err_o;
  assign lim_o   = lim_q;
  assign rdata_o = (32'(addr_i) < NUM_CLS) ? DATA_W'(lim_q[addr_i]) : '0;

  for (genvar i = 0; i < NUM_CLS; i++) begin : g_reg
    assign load_o[i] = wr_ok && (32'(addr_i) == i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        lim_q[i] <= LIM_RST;
      else if (load_o[i]) lim_q[i] <= wdata_i[LIM_W-1:0];
    end

    p_rsv_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_o && 32'(addr_i) == i) |=> $stable(lim_q[i]));
  end
endmodule

// File: rtl/bwl_credit_ctr.sv
module bwl_credit_ctr #(
  parameter int unsigned BW_LEN    = 11,
  parameter int unsigned BURST_MAX = 8,
  localparam int unsigned CR_W     = $clog2(BURST_MAX + 1),
  localparam int unsigned SUM_W    = bwl_pkg::bwl_max(BW_LEN, CR_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              spend_i,
  input  logic              load_i,
  input  logic [BW_LEN-1:0] lim_i,
  output logic              avail_o
);
  localparam logic [CR_W-1:0]  CR_CEIL  = CR_W'(BURST_MAX);
  localparam logic [SUM_W-1:0] SUM_CEIL = SUM_W'(BURST_MAX);

  logic [CR_W-1:0]  cr_q, cr_d, cr_spent;
  logic [SUM_W-1:0] sum;

  assign avail_o  = (cr_q != '0);
  assign cr_spent = spend_i ? (cr_q - 1'b1) : cr_q;
  assign sum      = SUM_W'(cr_spent) + SUM_W'(lim_i);

  always_comb begin
    cr_d = cr_spent;
    if (tick_i) cr_d = (sum > SUM_CEIL) ? CR_CEIL : sum[CR_W-1:0];
    if (load_i) cr_d = CR_CEIL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cr_q <= CR_CEIL;
    else         cr_q <= cr_d;
  end

  p_cr_ceiling_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_q <= CR_CEIL);
  p_spend_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spend_i && !tick_i && !load_i) |=> (cr_q == CR_W'($past(cr_q) - 1'b1)));
  p_load_ceiling_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cr_q == CR_CEIL));
  p_no_spend_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spend_i |-> avail_o);
endmodule

// File: rtl/rd_bw_limiter.sv
module rd_bw_limiter #(
  parameter int unsigned NUM_CLS     = bwl_pkg::BWL_DEF_CLS,
  parameter int unsigned BW_LEN      = bwl_pkg::BWL_DEF_BWLEN,
  parameter int unsigned DATA_W      = bwl_pkg::BWL_DEF_DATAW,
  parameter int unsigned CYC_PER_INT = bwl_pkg::BWL_DEF_CYC,
  parameter int unsigned BURST_MAX   = bwl_pkg::BWL_DEF_BURST,
  localparam int unsigned CLS_W      = (NUM_CLS > 1) ? $clog2(NUM_CLS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [CLS_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reg_err_o,
  input  logic              req_valid_i,
  input  logic [CLS_W-1:0]  req_cls_i,
  output logic              req_ready_o,
  output logic              out_valid_o,
  output logic [CLS_W-1:0]  out_cls_o,
  input  logic              out_ready_i
);
  localparam int unsigned LIM_W = BW_LEN + 1;

  logic                          tick;
  logic [NUM_CLS-1:0][LIM_W-1:0] lim;
  logic [NUM_CLS-1:0]            load, avail, unl, spend;
  logic                          pass, fire;

  bwl_tick_gen #(.CYC_PER_INT(CYC_PER_INT)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  bwl_limit_bank #(.NUM_CLS(NUM_CLS), .BW_LEN(BW_LEN), .DATA_W(DATA_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .err_o  (reg_err_o),
    .lim_o  (lim),
    .load_o (load)
  );

  for (genvar i = 0; i < NUM_CLS; i++) begin : g_cls
    assign unl[i]   = lim[i][BW_LEN];
    assign spend[i] = fire && !unl[i] && (32'(req_cls_i) == i);

    bwl_credit_ctr #(.BW_LEN(BW_LEN), .BURST_MAX(BURST_MAX)) u_cr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick),
      .spend_i(spend[i]),
      .load_i (load[i]),
      .lim_i  (lim[i][BW_LEN-1:0]),
      .avail_o(avail[i])
    );
  end

  // in-order stream: head request gates everything behind it
  assign pass        = (32'(req_cls_i) < NUM_CLS) && (unl[req_cls_i] || avail[req_cls_i]);
  assign out_valid_o = req_valid_i && pass;
  assign req_ready_o = out_ready_i && pass;
  assign out_cls_o   = req_cls_i;
  assign fire        = out_valid_o && out_ready_i;

  p_one_spend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(spend));
  p_hs_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |-> (out_valid_o && out_ready_i));
endmodule

// File: tb/rd_bw_limiter_tb_top.sv
module rd_bw_limiter_tb_top;
  localparam int NCLS = 4;
  localparam int BWL  = 4;
  localparam int DW   = 8;
  localparam int CYC  = 8;
  localparam int BMAX = 6;
  localparam int CW   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [CW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          err;
  logic          vld = 1'b0;
  logic [CW-1:0] cls = '0;
  logic          rdy;
  logic          ovld;
  logic [CW-1:0] ocls;
  logic          ordy = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int m_lim [NCLS];
  int m_cr  [NCLS];
  int m_tc;
  int cyc_cnt = 0;

  always #5 clk = ~clk;

  rd_bw_limiter #(.NUM_CLS(NCLS), .BW_LEN(BWL), .DATA_W(DW),
                  .CYC_PER_INT(CYC), .BURST_MAX(BMAX)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .reg_err_o(err),
    .req_valid_i(vld), .req_cls_i(cls), .req_ready_o(rdy),
    .out_valid_o(ovld), .out_cls_o(ocls), .out_ready_i(ordy)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive, check outputs against model, clock, update model
  task automatic step(input bit w, input int a, input int d, input bit v,
                      input int c, input bit r, input string tag);
    bit allow, e, tk;
    we = w; addr = CW'(a); wdata = DW'(d); vld = v; cls = CW'(c); ordy = r;
    #1;
    allow = ((m_lim[c] >> BWL) & 1) == 1 || m_cr[c] != 0;
    e     = w && ((d >> (BWL + 1)) != 0);
    chk(tag, "ready", int'(rdy), int'(r && allow));
    chk(tag, "out_valid", int'(ovld), int'(v && allow));
    chk(tag, "out_cls", int'(ocls), c);
    chk(tag, "err", int'(err), int'(e));
    chk("R2", "rdata", int'(rdata), m_lim[a]);
    @(posedge clk);
    tk   = (m_tc == CYC - 1);
    m_tc = tk ? 0 : m_tc + 1;
    if (v && r && allow && ((m_lim[c] >> BWL) & 1) == 0) m_cr[c]--;
    if (tk) for (int i = 0; i < NCLS; i++) begin
      m_cr[i] += m_lim[i] & ((1 << BWL) - 1);
      if (m_cr[i] > BMAX) m_cr[i] = BMAX;
    end
    if (w && !e) begin
      m_lim[a] = d;
      m_cr[a]  = BMAX;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, "R9");
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 100000) begin
        n_bad++;
        n_chk++;
        $display("FAIL watchdog act=%0d exp=<100000", cyc_cnt);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin : main
    for (int i = 0; i < NCLS; i++) begin
      m_lim[i] = 1 << BWL;
      m_cr[i]  = BMAX;
    end
    m_tc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset readback and pass-through for every class
    for (int i = 0; i < NCLS; i++) step(0, i, 0, 1, i, 1, "R1");
    // R4: unlimited class never stalls, limit field ignored
    for (int k = 0; k < 20; k++) step(0, 0, 0, 1, 0, 1, "R4");
    step(1, 0, 'h13, 0, 0, 0, "R2");
    for (int k = 0; k < 20; k++) step(0, 0, 0, 1, 0, 1, "R4");
    // R3: reserved bits fault, dropped
    step(1, 1, 'h23, 0, 0, 0, "R3");
    step(1, 1, 'h80, 0, 0, 0, "R3");
    step(0, 1, 0, 0, 0, 0, "R3");
    // R7/R5/R6: class 1 limit 2, saturated stream
    step(1, 1, 'h02, 0, 0, 0, "R7");
    for (int k = 0; k < 40; k++) step(0, 1, 0, 1, 1, 1, "R5");
    // R6: idle refill to ceiling, then drain
    idle(3 * CYC);
    for (int k = 0; k < 12; k++) step(0, 1, 0, 1, 1, 1, "R6");
    // R5: limit zero never refills
    step(1, 2, 'h00, 0, 0, 0, "R7");
    for (int k = 0; k < 30; k++) step(0, 2, 0, 1, 2, 1, "R5");
    // R8: class 3 unaffected by stalled class 2
    step(1, 3, 'h01, 0, 0, 0, "R8");
    for (int k = 0; k < 24; k++) step(0, 3, 0, 1, (k % 2 == 0) ? 2 : 3, 1, "R8");
    // R9: downstream back-pressure, no spend without handshake
    for (int k = 0; k < 24; k++) step(0, 3, 0, 1, 1 + (k % 3), (k % 4) != 0, "R9");
    // R10-style corner: write and spend same cycle, write wins (R7)
    step(1, 1, 'h03, 1, 1, 1, "R7");
    for (int k = 0; k < 10; k++) step(0, 1, 0, 1, 1, 1, "R7");
    // R4: back to unlimited via write, then flood
    step(1, 2, 'h10, 0, 0, 0, "R4");
    for (int k = 0; k < 16; k++) step(0, 2, 0, 1, 2, 1, "R4");
    // sweep: every class, every limit value, short bursts
    for (int c = 0; c < NCLS; c++)
      for (int l = 0; l < (1 << BWL); l += 3) begin
        step(1, c, l, 0, 0, 0, "R2");
        for (int k = 0; k < 2 * CYC; k++) step(0, c, 0, 1, c, (k % 5) != 4, "R6");
      end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule